// File: doc/BRIEF.md
# Burst-Fed Pairwise Averaging Accelerator

This block is a memory-to-memory engine. It reads an array of 1025 unsigned 32-bit words from external memory and writes 1024 results to a second array in the same memory. Each result is the halved sum of two neighbouring input words. Four lanes compute four results per iteration in lockstep, so a full run takes 256 iterations. Every iteration follows a fixed load, execute and store sequence.

Software programs the input and output base byte addresses, then pulses `start`. The block captures both bases and runs on its own until it pulses `done`. All traffic goes through a single bus master port. Separate valid/ready handshakes guard the address, read-data and write-data channels. Each command carries a direction flag and a burst length, and each beat of a burst sits 4 bytes above the one before it.

The last input word of an iteration is also the first one the next iteration needs, so the block keeps it in a register. As a result, no input word is ever fetched twice.

Top module: `pair_avg_accel`

## Requirements
- R1: Every written word equals the 32-bit truncated sum of its two neighbouring input words, shifted right by one: b[i] = ((a[i] + a[i+1]) mod 2^32) >> 1. Bit 31 of every written word is 0.
- R2: A run writes b[0]..b[1023] as 256 write bursts of 4 beats in ascending order. Burst j targets out_base + 16*j, and beat k of that burst goes to the burst address + 4*k.
- R3: A run issues exactly one single-beat read, at in_base, followed by one 4-beat read per iteration at in_base + 4*(r+1), where r = 4*j. bus_alen carries the beat count minus one, so 0 means a single beat and 3 means four beats.
- R4: Within one run, every input word a[0]..a[1024] is delivered to the block exactly once.
- R5: A write command is issued only after every beat of the preceding read has been accepted. A read command is issued only after the last beat of the preceding write burst has been accepted.
- R6: While bus_avalid is high and bus_aready is low, bus_avalid, bus_addr, bus_awrite and bus_alen hold their values. While bus_wvalid is high and bus_wready is low, bus_wvalid and bus_wdata hold their values.
- R7: `done` is high for exactly one cycle: the cycle after the final write beat of the run is accepted.
- R8: A `start` seen while a run is in progress, including the cycle in which `done` is high, is ignored and starts no new run. Changes to in_base and out_base after the accepted `start` have no effect on the run.
- R9: Out of reset the block is idle, with done, bus_avalid, bus_rready and bus_wvalid all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| in_base | input | 32 | Byte address of a[0] |
| out_base | input | 32 | Byte address of b[0] |
| done | output | 1 | One-cycle end-of-run pulse |
| bus_avalid | output | 1 | Command valid |
| bus_aready | input | 1 | Command accepted |
| bus_awrite | output | 1 | Command direction: 1 = write, 0 = read |
| bus_addr | output | 32 | Command start byte address |
| bus_alen | output | 2 | Beats minus one |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rready | output | 1 | Block accepts a read beat |
| bus_rdata | input | 32 | Read beat data |
| bus_wvalid | output | 1 | Write beat valid |
| bus_wready | input | 1 | Memory accepts a write beat |
| bus_wdata | output | 32 | Write beat data |

## Verification
Two events can coincide. The first is a fresh `start` arriving in the very cycle that `done` is high. The second is a new start, together with new base addresses, landing in the middle of a burst. The bench provokes the first case by raising `start` at the moment it sees `done`, then checks that no bus command follows for many cycles. It provokes the second case by pulsing `start` with altered bases halfway through a run, and the scoreboard then confirms that every address and data beat still matches the bases captured at the original start. A memory model that stalls at random on every channel is what lets these coincidences fall on different beats and phases.

// File: rtl/pair_avg_accel.sv
module pair_avg_accel #(
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int N_WORDS = 1024,
  parameter int LANES   = 4,
  localparam int LW     = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] in_base,
  input  logic [AW-1:0] out_base,
  output logic          done,
  output logic          bus_avalid,
  input  logic          bus_aready,
  output logic          bus_awrite,
  output logic [AW-1:0] bus_addr,
  output logic [LW-1:0] bus_alen,
  input  logic          bus_rvalid,
  output logic          bus_rready,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_wvalid,
  input  logic          bus_wready,
  output logic [DW-1:0] bus_wdata
);
  localparam int ITERS = N_WORDS / LANES;
  localparam int IW    = $clog2(ITERS);
  localparam int BSH   = $clog2(DW / 8);

  typedef enum logic [3:0] {
    S_IDLE, S_FA, S_FD, S_LA, S_LD, S_EX, S_SA, S_SD, S_FIN
  } state_t;

  state_t        state;
  logic [IW-1:0] iter;
  logic [LW-1:0] beat;
  logic [AW-1:0] ibase, obase, r_word;
  logic [LW:0]   wi;
  logic [DW-1:0] win [LANES+1];
  logic [DW-1:0] res [LANES];

  wire last_beat = beat == LW'(LANES - 1);
  wire last_iter = iter == IW'(ITERS - 1);

  assign r_word     = AW'(iter) << LW;
  assign wi         = {1'b0, beat} + 1'b1;
  assign bus_avalid = state inside {S_FA, S_LA, S_SA};
  assign bus_awrite = state == S_SA;
  assign bus_alen   = (state == S_FA) ? '0 : LW'(LANES - 1);
  assign bus_addr   = (state == S_SA) ? obase + (r_word << BSH) :
                      (state == S_LA) ? ibase + ((r_word + AW'(1)) << BSH) :
                                        ibase;
  assign bus_rready = state inside {S_FD, S_LD};
  assign bus_wvalid = state == S_SD;
  assign bus_wdata  = res[beat];
  assign done       = state == S_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      iter  <= '0;
      beat  <= '0;
      ibase <= '0;
      obase <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ibase <= in_base;
          obase <= out_base;
          iter  <= '0;
          state <= S_FA;
        end
        S_FA: if (bus_aready) state <= S_FD;
        S_FD: if (bus_rvalid) state <= S_LA;
        S_LA: if (bus_aready) begin
          beat  <= '0;
          state <= S_LD;
        end
        S_LD: if (bus_rvalid) begin
          beat <= beat + 1'b1;
          if (last_beat) state <= S_EX;
        end
        S_EX: state <= S_SA;
        S_SA: if (bus_aready) begin
          beat  <= '0;
          state <= S_SD;
        end
        S_SD: if (bus_wready) begin
          beat <= beat + 1'b1;
          if (last_beat) begin
            if (last_iter) state <= S_FIN;
            else begin
              iter  <= iter + 1'b1;
              state <= S_LA;
            end
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FD && bus_rvalid) win[0] <= bus_rdata;
    if (state == S_LD && bus_rvalid) win[wi] <= bus_rdata;
    if (state == S_SD && bus_wready && last_beat) win[0] <= win[LANES];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DW-1:0] sum;
    assign sum = win[k] + win[k+1];
    always_ff @(posedge clk)
      if (state == S_EX) res[k] <= sum >> 1;
  end
endmodule

// File: rtl/pair_avg_accel_chk.sv
module pair_avg_accel_chk #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          bus_avalid,
  input logic          bus_aready,
  input logic          bus_awrite,
  input logic [AW-1:0] bus_addr,
  input logic [LW-1:0] bus_alen,
  input logic          bus_rvalid,
  input logic          bus_rready,
  input logic          bus_wvalid,
  input logic          bus_wready,
  input logic [DW-1:0] bus_wdata
);
  logic [LW+1:0] wpend;
  logic [LW+1:0] rpend;
  logic          seen_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpend <= '0;
      rpend <= '0;
      seen_single <= 1'b0;
    end else begin
      if (bus_avalid && bus_aready && bus_awrite) wpend <= (LW+2)'(LANES);
      else if (bus_wvalid && bus_wready) wpend <= wpend - 1'b1;
      if (bus_avalid && bus_aready && !bus_awrite) rpend <= (LW+2)'(bus_alen) + 1'b1;
      else if (bus_rvalid && bus_rready) rpend <= rpend - 1'b1;
      if (done) seen_single <= 1'b0;
      else if (bus_avalid && bus_aready && !bus_awrite && bus_alen == '0) seen_single <= 1'b1;
    end
  end

  p_msb_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid |-> !bus_wdata[DW-1]);
  p_write_full_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_avalid && bus_awrite) |-> bus_alen == LW'(LANES - 1));
  p_single_read_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_avalid && bus_aready && !bus_awrite && bus_alen == '0) |-> !seen_single);
  p_read_after_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_avalid && !bus_awrite) |-> wpend == '0);
  p_store_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_avalid && bus_awrite) |-> rpend == '0);
  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_avalid && !bus_aready) |=> (bus_avalid && $stable(bus_addr) &&
                                     $stable(bus_awrite) && $stable(bus_alen)));
  p_wdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && !bus_wready) |=> (bus_wvalid && $stable(bus_wdata)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pair_avg_accel pair_avg_accel_chk #(.DW(DW), .AW(AW), .LANES(LANES)) u_chk (.*);

// File: tb/pair_avg_accel_tb.sv
module pair_avg_accel_tb;
  localparam int N = 1024;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] in_base = 0, out_base = 0;
  logic        done, bus_avalid, bus_aready = 0, bus_awrite;
  logic [31:0] bus_addr;
  logic [1:0]  bus_alen;
  logic        bus_rvalid = 0, bus_rready;
  logic [31:0] bus_rdata = 0;
  logic        bus_wvalid, bus_wready = 0;
  logic [31:0] bus_wdata;

  pair_avg_accel u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [int unsigned];
  int          rd_count [int unsigned];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];
  logic [31:0] run_in, run_out;
  int singles = 0, rbursts = 0, wbursts = 0, cmds = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: fill memory and push expected write beats
  task automatic load_run(input logic [31:0] ib, input logic [31:0] ob, input logic [31:0] seed);
    logic [31:0] a [N+1];
    for (int i = 0; i <= N; i++) begin
      a[i] = (i % 7 == 3) ? 32'hFFFF_FFFF : (32'(i) * 32'h9E37_79B9) ^ seed;
      mem[ib + 32'(4*i)] = a[i];
      rd_count[ib + 32'(4*i)] = 0;
    end
    for (int i = 0; i < N; i++) begin
      logic [31:0] s;
      s = a[i] + a[i+1];
      exp_addr.push_back(ob + 32'(4*i));
      exp_data.push_back(s >> 1);
    end
    run_in = ib; run_out = ob;
    singles = 0; rbursts = 0; wbursts = 0;
  endtask

  // memory responder with random stalls
  initial begin
    bit busy = 0, wr = 0;
    logic [31:0] base = 0;
    int len = 0, beat = 0;
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(posedge clk);
      if (bus_avalid && bus_aready) begin
        busy = 1; wr = bus_awrite; base = bus_addr;
        len = int'(bus_alen) + 1; beat = 0;
      end else if (busy && !wr && bus_rvalid && bus_rready) begin
        rd_count[base + 32'(4*beat)]++;
        beat++;
        if (beat == len) busy = 0;
      end else if (busy && wr && bus_wvalid && bus_wready) begin
        mem[base + 32'(4*beat)] = bus_wdata;
        beat++;
        if (beat == len) busy = 0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_aready <= !busy && (lfsr[1:0] != 2'b00);
      bus_rvalid <= busy && !wr && (lfsr[3:2] != 2'b00);
      bus_rdata  <= (busy && !wr) ? mem[base + 32'(4*beat)] : 32'h0;
      bus_wready <= busy && wr && (lfsr[5:4] != 2'b00);
    end
  end

  // monitor: scoreboard and protocol order
  initial begin
    int wpend = 0, rpend = 0, rb = 0;
    logic [31:0] waddr = 0, haddr = 0;
    bit hold = 0, was_done = 0;
    forever begin
      @(negedge clk);
      if (hold) chk(bus_avalid && bus_addr == haddr, "R6 command held", bus_addr, haddr);
      hold = bus_avalid && !bus_aready; haddr = bus_addr;
      if (was_done) chk(!done, "R7 done one cycle", 32'(done), 0);
      was_done = done;
      if (done) chk(exp_data.size() == 0 && wpend == 0, "R7 done after last write", 32'(exp_data.size()), 0);
      if (bus_avalid && bus_aready) begin
        cmds++;
        if (bus_awrite) begin
          chk(rpend == 0, "R5 store after load", 32'(rpend), 0);
          chk(bus_addr == run_out + 32'(16*wbursts), "R2 write burst address", bus_addr, run_out + 32'(16*wbursts));
          wbursts++; wpend = 4; waddr = bus_addr;
        end else begin
          chk(wpend == 0, "R5 load after store", 32'(wpend), 0);
          if (bus_alen == 2'd0) begin
            singles++;
            chk(bus_addr == run_in, "R3 single read address", bus_addr, run_in);
            rb = 0;
          end else begin
            chk(bus_addr == run_in + 32'(16*rb + 4), "R3 burst read address", bus_addr, run_in + 32'(16*rb + 4));
            rb++; rbursts++;
          end
          rpend = int'(bus_alen) + 1;
        end
      end
      if (bus_rvalid && bus_rready) rpend--;
      if (bus_wvalid && bus_wready) begin
        if (exp_data.size() == 0) chk(0, "R2 unexpected write", bus_wdata, 0);
        else begin
          logic [31:0] ea, ed;
          ea = exp_addr.pop_front(); ed = exp_data.pop_front();
          chk(waddr == ea, "R2 beat address", waddr, ea);
          chk(bus_wdata == ed, "R1 result word", bus_wdata, ed);
        end
        waddr += 4; wpend--;
      end
    end
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic end_checks(input string tag);
    int bad = 0;
    chk(exp_data.size() == 0, "R2 all words written", 32'(exp_data.size()), 0);
    chk(wbursts == 256, "R2 write burst count", 32'(wbursts), 256);
    chk(singles == 1, "R3 single reads", 32'(singles), 1);
    chk(rbursts == 256, "R3 burst reads", 32'(rbursts), 256);
    for (int i = 0; i <= N; i++)
      if (rd_count[run_in + 32'(4*i)] != 1) bad++;
    chk(bad == 0, "R4 each input read once", 32'(bad), 0);
    $display("run %s finished", tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !bus_avalid && !bus_rready && !bus_wvalid, "R9 reset outputs",
        {28'd0, done, bus_avalid, bus_rready, bus_wvalid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!bus_avalid && !done, "R9 idle without start", 32'(bus_avalid), 0);

    load_run(32'h0000_1000, 32'h0000_8000, 32'h1234_5678);
    in_base = 32'h0000_1000; out_base = 32'h0000_8000;
    start = 1; @(negedge clk); start = 0;
    repeat (1500) @(negedge clk);
    in_base = 32'h0004_0000; out_base = 32'h0005_0000;
    start = 1; @(negedge clk); start = 0;      // R8 mid-run start ignored
    wait_done();
    start = 1; @(negedge clk); start = 0;      // R8 start in done cycle
    end_checks("1");
    begin
      int c0;
      c0 = cmds;
      repeat (40) @(negedge clk);
      chk(cmds == c0, "R8 start in done cycle ignored", 32'(cmds - c0), 0);
    end

    load_run(32'h0002_0000, 32'h0003_0000, 32'hFFFF_0000);
    in_base = 32'h0002_0000; out_base = 32'h0003_0000;
    start = 1; @(negedge clk); start = 0;
    wait_done();
    @(negedge clk);
    end_checks("2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule